// File: doc/BRIEF.md
# Strobe-Qualified Word Capture Across Clock Domains

This block takes a parallel word from a slow source that has no known phase or frequency relation to the local clock and brings it safely into the fast clock domain. The source presents an 8-bit bus: the most significant bit is a strobe and the seven bits below it carry the payload. Every bus bit passes through a multi-flop synchroniser before any logic looks at it. A three-state controller then follows the synchronised strobe through its high and low phases.

A payload sample is taken on the first fast-clock cycle where the strobe is seen high. A second sample is taken on the first cycle where it is seen low again. When the two samples agree, the word is accepted: it is loaded into the output register and a valid flag is raised for exactly one fast-clock cycle. When they disagree, the word is rejected: a one-cycle mismatch flag is raised instead and the output keeps its earlier value. A strobe that is already high when reset is released is ignored until it has been seen low.

Top module: `strobe_capture`

## Requirements
- R1: While `rst_n` is low and after it is released, `data_out` reads 0 and `data_valid` and `data_mismatch` read 0 until a strobe pulse is completed.
- R2: In `bus_in`, bit 7 is the strobe (active high) and bits 6..0 are the payload word.
- R3: All bus bits pass through two synchronising flops. If the strobe's high-to-low change is applied before rising clock edge n, `data_valid` or `data_mismatch` is high in the cycle after rising edge n+3 and low in the cycle after rising edge n+2.
- R4: Each strobe pulse, high for at least 3 and low for at least 6 clock cycles, produces exactly one one-cycle pulse on either `data_valid` or `data_mismatch`, never on both, and `data_valid` is never high in two consecutive cycles.
- R5: When the payload reads the same at the strobe's rise and at its return low, `data_out` equals that payload in the cycle where `data_valid` is high.
- R6: When the payload read at the rise differs from the payload read at the return, `data_mismatch` pulses for one cycle, `data_valid` stays low and `data_out` keeps its previous value.
- R7: `data_out` changes only in a cycle where `data_valid` is high, and it holds its last accepted word between pulses. Payload changes while no strobe pulse is in progress have no effect on it.
- R8: A strobe that is high when reset is released produces no pulse on either flag, including when it later falls. Capture starts only with the next low-to-high strobe transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast capture clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | 8 | Bit 7 strobe, bits 6..0 payload, asynchronous to `clk` |
| data_out | output | 7 | Last accepted payload word |
| data_valid | output | 1 | One-cycle pulse when a new word is accepted |
| data_mismatch | output | 1 | One-cycle pulse when the two samples of a pulse disagree |

## Verification
The hardest situation to reach from the ports is a payload that changes while the strobe is high, so that the sample at the rise and the sample at the return differ. The stimulus creates it on purpose: in a random share of pulses, the bench switches to a second word a few cycles after the rise and well before the fall, so the synchroniser hands the controller two different values. A second awkward case is a strobe that is already high across the reset release. A directed sequence holds the strobe high through reset, then lowers it, and only after that sends normal pulses.

// File: rtl/strobe_capture_pkg.sv
package strobe_capture_pkg;

  typedef enum logic [1:0] {
    ST_AWAIT_HIGH = 2'd0,
    ST_AWAIT_LOW  = 2'd1,
    ST_DECIDE     = 2'd2
  } cap_state_e;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync,
  output logic             primed
);

  logic [WIDTH-1:0]  stage_q [STAGES];
  logic [STAGES-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  // primed goes high once every stage holds a sampled input value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= {fill_q[STAGES-2:0], 1'b1};
  end

  assign q_sync = stage_q[STAGES-1];
  assign primed = fill_q[STAGES-1];

  // R8: once primed, the synchroniser stays primed until reset
  a_r8_primed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);

endmodule

// File: rtl/strobe_fsm.sv
module strobe_fsm
  import strobe_capture_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strb_sync,
  input  logic primed,
  output logic take_first,
  output logic take_second,
  output logic decide
);

  cap_state_e state_q, state_d;
  logic       armed_q, armed_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAIT_HIGH: if (armed_q && strb_sync)  state_d = ST_AWAIT_LOW;
      ST_AWAIT_LOW:  if (!strb_sync)            state_d = ST_DECIDE;
      ST_DECIDE:                                state_d = ST_AWAIT_HIGH;
      default:                                  state_d = ST_AWAIT_HIGH;
    endcase
  end

  // a strobe only counts after a genuine low has been observed
  assign armed_d = armed_q | (primed & ~strb_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAIT_HIGH;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign take_first  = (state_q == ST_AWAIT_HIGH) && armed_q && strb_sync;
  assign take_second = (state_q == ST_AWAIT_LOW) && !strb_sync;
  assign decide      = (state_q == ST_DECIDE);

  // R4: the decision state lasts one cycle
  a_r4_decide_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECIDE) |=> (state_q == ST_AWAIT_HIGH));

  // R8: without a seen low, the controller does not leave its idle state
  a_r8_wait_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AWAIT_HIGH && !armed_q) |=> (state_q == ST_AWAIT_HIGH));

  a_r4_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_q inside {ST_AWAIT_HIGH, ST_AWAIT_LOW, ST_DECIDE});

endmodule

// File: rtl/sample_compare.sv
module sample_compare #(
  parameter int W_DATA = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W_DATA-1:0] data_sync,
  input  logic              take_first,
  input  logic              take_second,
  input  logic              decide,
  output logic [W_DATA-1:0] word_q,
  output logic              valid_q,
  output logic              mismatch_q
);

  logic [W_DATA-1:0] first_q, second_q;
  logic              same;
  logic              load_word;

  assign same      = (first_q == second_q);
  assign load_word = decide & same;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          first_q <= '0;
    else if (take_first) first_q <= data_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           second_q <= '0;
    else if (take_second) second_q <= data_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (load_word) word_q <= first_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      mismatch_q <= 1'b0;
    end else begin
      valid_q    <= decide & same;
      mismatch_q <= decide & ~same;
    end
  end

  // R4: valid never lasts two cycles
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R4: the two outcome flags are exclusive
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && mismatch_q));

  // R5: the accepted word is the first sample of the pulse
  a_r5_word_is_first: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (word_q == $past(first_q)));

  // R6: a rejected pulse leaves the output word alone
  a_r6_hold_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_q |-> $stable(word_q));

  // R7: the output word moves only together with valid
  a_r7_change_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> valid_q);

endmodule

// File: rtl/strobe_capture.sv
module strobe_capture #(
  parameter int W_DATA      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W_DATA:0]   bus_in,
  output logic [W_DATA-1:0] data_out,
  output logic              data_valid,
  output logic              data_mismatch
);

  localparam int W_BUS = W_DATA + 1;
  localparam int STRB  = W_DATA;

  logic             rst_n_int;
  logic [W_BUS-1:0] bus_sync;
  logic             primed;
  logic             take_first, take_second, decide;

  rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  cdc_sync #(.WIDTH(W_BUS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (bus_in),
    .q_sync  (bus_sync),
    .primed  (primed)
  );

  strobe_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .strb_sync   (bus_sync[STRB]),
    .primed      (primed),
    .take_first  (take_first),
    .take_second (take_second),
    .decide      (decide)
  );

  sample_compare #(.W_DATA(W_DATA)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .data_sync   (bus_sync[W_DATA-1:0]),
    .take_first  (take_first),
    .take_second (take_second),
    .decide      (decide),
    .word_q      (data_out),
    .valid_q     (data_valid),
    .mismatch_q  (data_mismatch)
  );

  // R1: reset leaves every output quiet
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n_int |-> (data_out == '0 && !data_valid && !data_mismatch));

endmodule

// File: tb/tb_strobe_capture.sv
module tb_strobe_capture;

  logic       clk;
  logic       rst_n;
  logic [7:0] bus_in;
  logic [6:0] data_out;
  logic       data_valid;
  logic       data_mismatch;

  int checks = 0;
  int errors = 0;

  int         n_valid, n_mism;
  logic       prev_valid;
  int         dbl_valid;
  logic [6:0] word_at_valid;
  int         n_change_nov;
  logic [6:0] prev_out;

  strobe_capture dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_in        (bus_in),
    .data_out      (data_out),
    .data_valid    (data_valid),
    .data_mismatch (data_mismatch)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // observation away from the active edge
  always @(negedge clk) begin
    if (data_valid) begin
      n_valid++;
      word_at_valid = data_out;
      if (prev_valid) dbl_valid++;
    end
    if (data_mismatch) n_mism++;
    if (data_out !== prev_out && !data_valid) n_change_nov++;
    prev_valid = data_valid;
    prev_out   = data_out;
  end

  function automatic logic expect_accept(input logic [6:0] a, input logic [6:0] b);
    return a == b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_valid = 0; n_mism = 0; dbl_valid = 0; n_change_nov = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one pulse: rise with w0, optionally switch to w1 mid-high, fall
  task automatic pulse(input logic [6:0] w0, input logic [6:0] w1,
                       input int hi, input int lo);
    bus_in = {1'b1, w0};
    idle(3);
    bus_in = {1'b1, w1};
    idle(hi - 3);
    bus_in = {1'b0, w1};
    idle(lo);
  endtask

  logic [6:0] model_out;

  task automatic pulse_and_check(input logic [6:0] w0, input logic [6:0] w1,
                                 input int hi, input int lo);
    logic acc;
    clear_counts();
    pulse(w0, w1, hi, lo);
    acc = expect_accept(w0, w1);
    check(n_valid + n_mism == 1, "R4", n_valid + n_mism, 1);
    check(dbl_valid == 0, "R4", dbl_valid, 0);
    if (acc) begin
      check(n_valid == 1 && word_at_valid == w0, "R5", int'(word_at_valid), int'(w0));
      model_out = w0;
    end else begin
      check(n_mism == 1 && n_valid == 0, "R6", n_valid, 0);
    end
    check(data_out == model_out, "R7", int'(data_out), int'(model_out));
    check(n_change_nov == 0, "R7", n_change_nov, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    prev_valid = 1'b0;
    prev_out   = '0;
    clear_counts();
    model_out = '0;

    // R8 setup: strobe already high through reset
    rst_n  = 1'b0;
    bus_in = {1'b1, 7'h55};
    idle(4);
    check(data_out == 0 && !data_valid && !data_mismatch, "R1", int'(data_out), 0);
    rst_n = 1'b1;
    clear_counts();
    idle(10);
    check(data_out == 0 && !data_valid && !data_mismatch, "R1", int'(data_out), 0);
    bus_in = {1'b0, 7'h55};
    idle(12);
    check(n_valid + n_mism == 0, "R8", n_valid + n_mism, 0);

    // R2/R5: basic accepted pulse
    pulse_and_check(7'h2A, 7'h2A, 8, 10);
    check(data_out == 7'h2A, "R2", int'(data_out), 'h2A);

    // R6: payload differs between rise and return
    pulse_and_check(7'h11, 7'h6E, 10, 10);

    // R7: payload moving while strobe is low changes nothing
    clear_counts();
    for (int i = 0; i < 6; i++) begin
      bus_in = {1'b0, 7'(i * 19 + 3)};
      idle(3);
    end
    check(n_valid + n_mism == 0 && data_out == model_out, "R7", int'(data_out), int'(model_out));

    // R3: exact latency from the falling strobe
    bus_in = {1'b1, 7'h7F};
    idle(10);
    bus_in = {1'b0, 7'h7F};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!data_valid && !data_mismatch, "R3", int'(data_valid), 0);
    @(posedge clk);
    @(negedge clk);
    check(data_valid && data_out == 7'h7F, "R3", int'(data_valid), 1);
    idle(8);
    model_out = 7'h7F;

    // boundary words and minimum pulse lengths
    pulse_and_check(7'h00, 7'h00, 3, 6);
    pulse_and_check(7'h7F, 7'h7F, 3, 6);
    pulse_and_check(7'h01, 7'h40, 6, 6);

    // constrained random pulses
    for (int k = 0; k < 300; k++) begin
      logic [6:0] a, b;
      int hi, lo;
      a  = 7'($urandom);
      b  = ($urandom_range(0, 9) < 3) ? 7'($urandom) : a;
      hi = $urandom_range(6, 20);
      lo = $urandom_range(6, 20);
      pulse_and_check(a, b, hi, lo);
    end

    // R1: reset in the middle of operation clears the word
    rst_n = 1'b0;
    idle(2);
    check(data_out == 0 && !data_valid, "R1", int'(data_out), 0);
    rst_n = 1'b1;
    idle(4);
    model_out = '0;
    prev_out  = '0;
    pulse_and_check(7'h33, 7'h33, 8, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule